// File: doc/BRIEF.md
# Selection Timeout Timer

This block times how long a SCSI controller waits for a target to answer during selection or reselection. The host programs two small registers through a clocked write port: a clock conversion factor and a timeout in whole time units. When arbitration is won and the selection phase begins, a start pulse launches the timer. When the target responds, a stop pulse cancels it. If no stop arrives in time, the timer emits a one-cycle expire pulse. That pulse drives the disconnect-or-timeout interrupt event, which is bit 5 of the interrupt register.

One time unit is `UNIT_MULT` times the effective conversion factor, counted in input clocks. `UNIT_MULT` defaults to 7682. The conversion factor is normally the input frequency in MHz, rounded up to a multiple of 5, then divided by 5. Values below the legal minimum of 2 are raised to 2. A timeout value of 0 stands for 256 units. A prescaler counts the clocks in each unit, and a unit counter counts the units. Both reload from the registers on every start pulse, so a run always uses the values that were in place when it began.

Top module: `sel_timeout_timer`

## Requirements
- R1: After a start pulse is sampled at a rising edge, expire goes high just after the N-th following rising edge and not earlier. N = units × `UNIT_MULT` × effective conversion factor.
- R2: A write with `wr_sel`=0 loads the conversion factor from `wr_data[2:0]`; the other data bits are ignored. A stored value of 0 or 1 acts as 2, and values 2 to 7 are used as written.
- R3: A write with `wr_sel`=1 loads the timeout from `wr_data[7:0]` in units. A stored value of 0 means 256 units.
- R4: A start pulse while the timer runs restarts both counters from the current registers. Register writes made during a run do not change that run's expiry time.
- R5: A stop pulse cancels a running timer and no expire follows. This also holds when the stop falls on the edge where expiry would occur. A start and a stop in the same cycle leave the timer idle.
- R6: Expire is high for exactly one cycle per run. After it the timer is idle and gives no further expire until a new start.
- R7: After reset, expire is low, the timer is idle, and both registers hold 0, so the first run lasts 256 units at a factor of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the timing base |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Register select: 0 conversion factor, 1 timeout |
| wr_data | input | 8 | Host write data |
| start | input | 1 | Begin timing (selection phase started) |
| stop | input | 1 | Cancel timing (target answered) |
| expire | output | 1 | One-cycle timeout event pulse |

## Verification
The assertions check these rules on every cycle:
- expire never stays high for two cycles;
- expire never follows an idle cycle or a stop;
- a lone start leaves the timer running;
- the timer is idle whenever expire is high.

Only the bench's scenarios can show that expiry lands on the exact clock given by units × multiplier × factor. The same holds for the clamping of small conversion factors, the meaning of 0 as 256 units, register capture at start, and restart. These are measured over full runs at a reduced multiplier, and once at the full 7682 multiplier.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // Host register selector values
  typedef enum logic {
    SST_REG_CCF = 1'b0,
    SST_REG_TMO = 1'b1
  } sst_reg_e;
endpackage

// File: rtl/sst_cfg_regs.sv
module sst_cfg_regs
  import sst_pkg::*;
#(
  parameter int UNIT_MULT = 7682,
  parameter int CCF_W     = 3,
  parameter int CCF_MIN   = 2,
  parameter int TMO_W     = 8,
  parameter int PRE_W     = 16,
  parameter int UNIT_W    = TMO_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [TMO_W-1:0]  wr_data,
  output logic [PRE_W-1:0]  period_m1,
  output logic [UNIT_W-1:0] unit_load
);
  logic [CCF_W-1:0] ccf_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CCF_W-1:0] ccf_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccf_q <= '0;
      tmo_q <= '0;
    end else if (wr_en) begin
      if (sst_reg_e'(wr_sel) == SST_REG_TMO) tmo_q <= wr_data;
      else                                   ccf_q <= wr_data[CCF_W-1:0];
    end
  end

  // R2: clamp illegal small factors to the minimum
  always_comb begin
    ccf_eff = (ccf_q < CCF_W'(CCF_MIN)) ? CCF_W'(CCF_MIN) : ccf_q;
    period_m1 = PRE_W'(UNIT_MULT) * PRE_W'(ccf_eff) - PRE_W'(1);
    // R3: zero encodes the largest count
    unit_load = (tmo_q == '0) ? UNIT_W'(1 << TMO_W) : {1'b0, tmo_q};
  end
endmodule

// File: rtl/sst_unit_prescaler.sv
module sst_unit_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [PRE_W-1:0] reload_val,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt_q    <= reload_val;
      reload_q <= reload_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - PRE_W'(1);
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/sst_unit_counter.sv
module sst_unit_counter #(
  parameter int UNIT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              cancel,
  input  logic              tick,
  input  logic [UNIT_W-1:0] unit_load,
  output logic              running,
  output logic              expire
);
  logic [UNIT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (cancel) begin
        running <= 1'b0;
      end else if (load) begin
        running <= 1'b1;
        left_q  <= unit_load;
      end else if (running && tick) begin
        if (left_q == UNIT_W'(1)) begin
          running <= 1'b0;
          expire  <= 1'b1;
        end else begin
          left_q <= left_q - UNIT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sel_timeout_timer.sv
module sel_timeout_timer #(
  parameter int UNIT_MULT = 7682,
  parameter int CCF_W     = 3,
  parameter int CCF_MIN   = 2,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [TMO_W-1:0] wr_data,
  input  logic             start,
  input  logic             stop,
  output logic             expire
);
  localparam int CCF_MAX = (1 << CCF_W) - 1;
  localparam int PRE_W   = $clog2(UNIT_MULT * CCF_MAX + 1);
  localparam int UNIT_W  = TMO_W + 1;

  logic [PRE_W-1:0]  period_m1;
  logic [UNIT_W-1:0] unit_load;
  logic              launch;
  logic              unit_tick;
  logic              timer_running;

  // R5: a stop in the same cycle suppresses the launch
  assign launch = start && !stop;

  sst_cfg_regs #(
    .UNIT_MULT(UNIT_MULT), .CCF_W(CCF_W), .CCF_MIN(CCF_MIN),
    .TMO_W(TMO_W), .PRE_W(PRE_W), .UNIT_W(UNIT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_m1(period_m1), .unit_load(unit_load)
  );

  sst_unit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .load(launch), .run(timer_running),
    .reload_val(period_m1), .tick(unit_tick)
  );

  sst_unit_counter #(.UNIT_W(UNIT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(launch), .cancel(stop), .tick(unit_tick),
    .unit_load(unit_load), .running(timer_running), .expire(expire)
  );
endmodule

// File: rtl/sel_timeout_timer_chk.sv
module sel_timeout_timer_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic stop,
  input logic expire,
  input logic timer_running
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  a_r6_idle_after_expire: assert property (@(posedge clk) disable iff (rst)
    expire |-> !timer_running);

  a_r5_stop_blocks_expire: assert property (@(posedge clk) disable iff (rst)
    stop |=> !expire);

  a_r1_no_expire_from_idle: assert property (@(posedge clk) disable iff (rst)
    !timer_running |=> !expire);

  a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
    (start && !stop) |=> timer_running);
endmodule

bind sel_timeout_timer sel_timeout_timer_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .stop(stop),
  .expire(expire), .timer_running(timer_running)
);

// File: tb/test_sel_timeout_timer.sv
module test_sel_timeout_timer;
  localparam int SMALL_MULT = 3;
  localparam int FULL_MULT  = 7682;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic       expire_s;
  logic       expire_f;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sel_timeout_timer #(.UNIT_MULT(SMALL_MULT)) i_sel_timeout_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .stop(stop), .expire(expire_s)
  );

  sel_timeout_timer #(.UNIT_MULT(FULL_MULT)) i_sel_timeout_timer_full (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .stop(stop), .expire(expire_f)
  );

  function automatic int exp_cycles(input int ccf_raw, input int tmo, input int mult);
    int c, u;
    c = ((ccf_raw & 7) < 2) ? 2 : (ccf_raw & 7);
    u = (tmo == 0) ? 256 : tmo;
    return u * mult * c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input int data);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = 8'(data);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Count cycles until expire from the current negedge; base adds elapsed cycles
  task automatic wait_expire(input bit full, input int limit, input int base, output int n);
    bit found = 1'b0;
    n = base;
    while (!found && n <= limit) begin
      if (full ? expire_f : expire_s) found = 1'b1;
      else begin @(negedge clk); n++; end
    end
    if (!found) n = -1;
  endtask

  // Returns number of expire cycles seen on the small instance within len cycles
  task automatic watch(input int len, output int seen);
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (expire_s) seen++;
    end
  endtask

  task automatic run_case(input int ccf, input int tmo, input string req);
    int n, e, seen;
    wr(1'b0, ccf);
    wr(1'b1, tmo);
    e = exp_cycles(ccf, tmo, SMALL_MULT);
    pulse_start();
    wait_expire(1'b0, e + 20, 0, n);
    check(n == e, req, n, e);
    watch(e + 5, seen);
    check(seen == 0, "R6 single pulse then idle", seen, 0);
  endtask

  initial begin
    int n, e, seen;
    int unsigned seed_init;
    seed_init = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(expire_s == 1'b0, "R7 expire low after reset", int'(expire_s), 0);

    // R7/R3: reset defaults give 256 units at factor 2
    e = exp_cycles(0, 0, SMALL_MULT);
    pulse_start();
    wait_expire(1'b0, e + 20, 0, n);
    check(n == e, "R7 reset defaults 256 units", n, e);
    @(negedge clk);
    check(expire_s == 1'b0, "R6 expire one cycle", int'(expire_s), 0);

    // R1 basic, R2 clamp, R3 zero
    run_case(2, 1, "R1 one unit factor 2");
    run_case(7, 3, "R1 factor 7 three units");
    run_case(0, 2, "R2 factor 0 acts as 2");
    run_case(1, 2, "R2 factor 1 acts as 2");
    run_case(8'hFB, 2, "R2 upper data bits ignored");
    run_case(3, 0, "R3 zero means 256 units");
    run_case(5, 255, "R3 max explicit count");

    // Random mix
    for (int k = 0; k < 12; k++) begin
      run_case(int'($urandom % 8), 1 + int'($urandom % 20), "R1 random run");
    end

    // R5: stop midway cancels
    wr(1'b0, 4); wr(1'b1, 5);
    e = exp_cycles(4, 5, SMALL_MULT);
    pulse_start();
    repeat (e / 2) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    watch(e + 10, seen);
    check(seen == 0, "R5 stop midway cancels", seen, 0);

    // R5: stop on the edge of expiry
    pulse_start();
    repeat (e - 1) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    check(expire_s == 1'b0, "R5 stop at expiry edge", int'(expire_s), 0);
    watch(e + 10, seen);
    check(seen == 0, "R5 stop at expiry edge later", seen, 0);

    // R5: start and stop together
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    watch(e + 10, seen);
    check(seen == 0, "R5 start with stop stays idle", seen, 0);

    // R4: restart while running
    pulse_start();
    repeat (e - 5) @(negedge clk);
    pulse_start();
    wait_expire(1'b0, e + 20, 0, n);
    check(n == e, "R4 restart reloads counters", n, e);

    // R4: writes during a run do not change it
    wr(1'b0, 2); wr(1'b1, 4);
    e = exp_cycles(2, 4, SMALL_MULT);
    pulse_start();
    wr(1'b1, 1);
    wr(1'b0, 7);
    wait_expire(1'b0, e + 20, 4, n);
    check(n == e, "R4 run uses values captured at start", n, e);
    // next run uses the new values
    e = exp_cycles(7, 1, SMALL_MULT);
    pulse_start();
    wait_expire(1'b0, e + 20, 0, n);
    check(n == e, "R4 new values apply to next run", n, e);

    // R1 at full multiplier
    wr(1'b0, 2); wr(1'b1, 1);
    e = exp_cycles(2, 1, FULL_MULT);
    pulse_start();
    wait_expire(1'b1, e + 20, 0, n);
    check(n == e, "R1 full multiplier unit length", n, e);
    @(negedge clk);
    check(expire_f == 1'b0, "R6 full expire one cycle", int'(expire_f), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule